// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block applies the result of one bus transaction to a transfer descriptor. It takes the descriptor's 32-bit control word, its 32-bit token word and a transaction outcome, which is either a byte count or one of the error kinds: no device, NAK, stall or babble. From these it produces three things:

- the control word to write back;
- a result code that tells the list walker what to do next;
- the interrupt and error causes that the frame gathers.

It also decodes the token continuously, so the transaction issuer has the packet identifier, device address, endpoint and maximum length before the transaction runs.

The block has a two-state machine. It sits in `ST_IDLE`. A cycle with `in_valid` high takes it to `ST_REPORT` (transition `ACCEPT`). While in `ST_REPORT`, another `in_valid` keeps it there (transition `CHAIN`), and otherwise it goes back to `ST_IDLE` (transition `DRAIN`). `out_valid` is high exactly while the machine is in `ST_REPORT`. The registered results stay stable until the next accepted descriptor.

Top module: `td_status_updater`

## Requirements
- R1: When control bit 23 (active) is clear, the control word passes through unchanged and the result is stay (code 1). Error outputs stay low, and `cause_ioc` equals control bit 24.
- R2: Token decode, combinational from `td_token`. The PID is bits 7:0, the address is bits 14:8, the endpoint is bits 18:15, and the maximum length is (bits 31:21 + 1) mod 2048.
- R3: Outputs update on the clock edge that samples `in_valid`, and `out_valid` is high for exactly the cycles after an accepted strobe. After reset every output register is zero.
- R4: For an active descriptor with a legal PID, status bits 17 to 22 of the input word are cleared before the outcome is applied.
- R5: Outcome code 0 (data) is a success. The word gets (length − 1) mod 2048 in bits 10:0 and active cleared, and the result is advance (code 0). For OUT (0xE1) and SETUP (0x2D), the length is the maximum length, whatever the count.
- R6: For IN (0x69), a count above the maximum length is treated as babble.
- R7: A successful IN with bit 29 set and length below the maximum raises `cause_short` and returns stay. Without bit 29, it returns advance.
- R8: Outcome 1 (no device), and any unused code 5 to 7, is a timeout. It sets bit 18. If counter bits 28:27 are nonzero they are decremented, and reaching zero clears active and raises `err_ctl`. A zero counter stays zero and keeps active set. The result is stay.
- R9: Outcome 2 (NAK) sets bit 19, keeps active and returns stay. A NAK to SETUP is also handled as a timeout, following R8.
- R10: Outcome 3 (stall) sets bit 22, clears active and returns stay.
- R11: Babble, whether outcome 4 or from R6, sets bits 20 and 22, clears active, leaves bits 10:0 unchanged and returns abort (code 2).
- R12: An active descriptor with any other PID raises `err_proc`, returns abort and leaves the word unchanged.
- R13: When bit 25 is set on an active descriptor with a legal PID, active is cleared in the output whatever the outcome.
- R14: For an active descriptor with a legal PID, `cause_ioc` is raised exactly when bit 24 is set and the output active bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor and outcome are valid this cycle |
| td_ctrl | input | 32 | Descriptor control word |
| td_token | input | 32 | Descriptor token word |
| xfer_outcome | input | 3 | Outcome kind: 0 data, 1 no device, 2 NAK, 3 stall, 4 babble |
| xfer_count | input | CNT_W (12) | Byte count returned for a data outcome |
| pkt_pid | output | 8 | Decoded packet identifier |
| pkt_addr | output | 7 | Decoded device address |
| pkt_endp | output | 4 | Decoded endpoint |
| pkt_maxlen | output | 11 | Decoded maximum length |
| out_valid | output | 1 | Registered results are new this cycle |
| upd_ctrl | output | 32 | Updated control word |
| upd_result | output | 2 | 0 advance, 1 stay, 2 abort |
| cause_ioc | output | 1 | Completion interrupt cause |
| cause_short | output | 1 | Short packet cause |
| err_ctl | output | 1 | Retry counter exhausted |
| err_proc | output | 1 | Illegal PID |

## Verification
The bench goes after the edges of the retry counter: 3 to 2, 1 to 0 and an already exhausted 0. A design that mishandled these would raise the controller error too early, or wrap the counter to 3. It checks an IN count one above the maximum, and a design with an off-by-one compare there would report success instead of aborting the frame. It checks the maximum-length field at 0x7FF, where the length wraps to zero and the written length wraps to 0x7FF. Further cases target the NAK to SETUP promotion, isochronous forcing of active under a NAK, and pass-through of inactive and illegal-PID words, including stale status bits. A design that got these wrong would retry a SETUP forever, leave an isochronous descriptor live, or corrupt words it must not touch.

// File: rtl/td_pkg.sv
package td_pkg;
    localparam int CW        = 32;
    localparam int LEN_W     = 11;
    localparam int B_SPD     = 29;
    localparam int B_ERR_HI  = 28;
    localparam int B_ERR_LO  = 27;
    localparam int B_IOS     = 25;
    localparam int B_IOC     = 24;
    localparam int B_ACT     = 23;
    localparam int B_STALL   = 22;
    localparam int B_BABBLE  = 20;
    localparam int B_NAK     = 19;
    localparam int B_TMO     = 18;
    localparam logic [CW-1:0] STATUS_MASK = 32'h007E_0000;

    localparam logic [7:0] PID_OUT   = 8'hE1;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_SETUP = 8'h2D;

    localparam logic [2:0] OC_DATA   = 3'd0;
    localparam logic [2:0] OC_NODEV  = 3'd1;
    localparam logic [2:0] OC_NAK    = 3'd2;
    localparam logic [2:0] OC_STALL  = 3'd3;
    localparam logic [2:0] OC_BABBLE = 3'd4;

    typedef enum logic [1:0] {
        RES_ADVANCE = 2'd0,
        RES_STAY    = 2'd1,
        RES_ABORT   = 2'd2
    } result_e;

    typedef struct packed {
        logic [CW-1:0] ctrl;
        result_e       res;
        logic          ioc;
        logic          short_pkt;
        logic          ctl_err;
        logic          proc_err;
    } upd_t;
endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
    import td_pkg::*;
(
    input  logic [CW-1:0]    tok,
    output logic [7:0]       pid,
    output logic [6:0]       dev_addr,
    output logic [3:0]       endp,
    output logic [LEN_W-1:0] maxlen,
    output logic             pid_ok,
    output logic             is_in,
    output logic             is_setup
);
    logic unused_tok;
    assign unused_tok = ^tok[20:19];

    always_comb begin
        pid      = tok[7:0];
        dev_addr = tok[14:8];
        endp     = tok[18:15];
        maxlen   = tok[31:21] + LEN_W'(1);
        is_in    = (pid == PID_IN);
        is_setup = (pid == PID_SETUP);
        pid_ok   = is_in || is_setup || (pid == PID_OUT);
    end
endmodule

// File: rtl/td_status_calc.sv
module td_status_calc
    import td_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CW-1:0]    ctrl,
    input  logic [LEN_W-1:0] maxlen,
    input  logic             pid_ok,
    input  logic             is_in,
    input  logic             is_setup,
    input  logic [2:0]       outcome,
    input  logic [CNT_W-1:0] count,
    output upd_t             upd
);
    logic [CW-1:0]    c;
    logic [2:0]       kind;
    logic [LEN_W-1:0] len;
    logic [1:0]       errc;

    always_comb begin
        upd  = '0;
        c    = ctrl & ~STATUS_MASK;
        kind = outcome;
        len  = maxlen;
        errc = 2'd0;
        if (!ctrl[B_ACT]) begin
            upd.ctrl = ctrl;
            upd.res  = RES_STAY;
            upd.ioc  = ctrl[B_IOC];
        end else if (!pid_ok) begin
            upd.ctrl     = ctrl;
            upd.res      = RES_ABORT;
            upd.proc_err = 1'b1;
        end else begin
            if (outcome == OC_DATA && is_in) begin
                if (count > CNT_W'(maxlen)) kind = OC_BABBLE;
                else                        len  = count[LEN_W-1:0];
            end
            if (kind == OC_NAK) begin
                c[B_NAK] = 1'b1;
                if (is_setup) kind = OC_NODEV;
            end
            case (kind)
                OC_DATA: begin
                    c[LEN_W-1:0] = len - LEN_W'(1);
                    c[B_ACT]     = 1'b0;
                    if (is_in && ctrl[B_SPD] && (len < maxlen)) begin
                        upd.short_pkt = 1'b1;
                        upd.res       = RES_STAY;
                    end else begin
                        upd.res = RES_ADVANCE;
                    end
                end
                OC_NAK: upd.res = RES_STAY;
                OC_STALL: begin
                    c[B_STALL] = 1'b1;
                    c[B_ACT]   = 1'b0;
                    upd.res    = RES_STAY;
                end
                OC_BABBLE: begin
                    c[B_STALL]  = 1'b1;
                    c[B_BABBLE] = 1'b1;
                    c[B_ACT]    = 1'b0;
                    upd.res     = RES_ABORT;
                end
                default: begin
                    c[B_TMO] = 1'b1;
                    errc     = c[B_ERR_HI:B_ERR_LO];
                    if (errc != 2'd0) begin
                        errc = errc - 2'd1;
                        if (errc == 2'd0) begin
                            c[B_ACT]    = 1'b0;
                            upd.ctl_err = 1'b1;
                        end
                    end
                    c[B_ERR_HI:B_ERR_LO] = errc;
                    upd.res = RES_STAY;
                end
            endcase
            if (c[B_IOS]) c[B_ACT] = 1'b0;
            upd.ctrl = c;
            upd.ioc  = c[B_IOC] & ~c[B_ACT];
        end
    end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
    import td_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      td_ctrl,
    input  logic [31:0]      td_token,
    input  logic [2:0]       xfer_outcome,
    input  logic [CNT_W-1:0] xfer_count,
    output logic [7:0]       pkt_pid,
    output logic [6:0]       pkt_addr,
    output logic [3:0]       pkt_endp,
    output logic [10:0]      pkt_maxlen,
    output logic             out_valid,
    output logic [31:0]      upd_ctrl,
    output logic [1:0]       upd_result,
    output logic             cause_ioc,
    output logic             cause_short,
    output logic             err_ctl,
    output logic             err_proc
);
    typedef enum logic {ST_IDLE = 1'b0, ST_REPORT = 1'b1} state_e;

    state_e state, state_nx;
    logic   pid_ok, is_in, is_setup;
    upd_t   upd_c, upd_q;

    td_token_decode u_dec (
        .tok      (td_token),
        .pid      (pkt_pid),
        .dev_addr (pkt_addr),
        .endp     (pkt_endp),
        .maxlen   (pkt_maxlen),
        .pid_ok   (pid_ok),
        .is_in    (is_in),
        .is_setup (is_setup)
    );

    td_status_calc #(.CNT_W(CNT_W)) u_calc (
        .ctrl     (td_ctrl),
        .maxlen   (pkt_maxlen),
        .pid_ok   (pid_ok),
        .is_in    (is_in),
        .is_setup (is_setup),
        .outcome  (xfer_outcome),
        .count    (xfer_count),
        .upd      (upd_c)
    );

    // next-state: ACCEPT / CHAIN on in_valid, DRAIN otherwise
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        upd_q <= '0;
        else if (in_valid) upd_q <= upd_c;
    end

    always_comb begin
        out_valid   = (state == ST_REPORT);
        upd_ctrl    = upd_q.ctrl;
        upd_result  = upd_q.res;
        cause_ioc   = upd_q.ioc;
        cause_short = upd_q.short_pkt;
        err_ctl     = upd_q.ctl_err;
        err_proc    = upd_q.proc_err;
    end

    // R1: inactive descriptors pass through untouched
    a_r1_inactive_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !td_ctrl[B_ACT] |=> upd_ctrl == $past(td_ctrl) && upd_result == 2'd1);
    // R3: one report cycle per accepted strobe
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7: a short packet never advances
    a_r7_short_stays: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cause_short |-> upd_result == 2'd1 && !upd_ctrl[B_ACT]);
    // R8: controller error only with an exhausted counter and timeout flag
    a_r8_err_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && err_ctl |-> upd_ctrl[B_ERR_HI:B_ERR_LO] == 2'd0 && upd_ctrl[B_TMO] && !upd_ctrl[B_ACT]);
    // R11: a frame abort without an illegal PID carries babble status
    a_r11_abort_babble: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && upd_result == 2'd2 && !err_proc |-> upd_ctrl[B_BABBLE] && upd_ctrl[B_STALL] && !upd_ctrl[B_ACT]);
    // R14: completion cause needs a retired descriptor with the IOC bit
    a_r14_ioc_retired: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cause_ioc |-> upd_ctrl[B_IOC] && !upd_ctrl[B_ACT]);
endmodule

// File: tb/tb_td_status_updater.sv
`timescale 1ns/1ps
module tb_td_status_updater;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] td_ctrl = '0;
    logic [31:0] td_token = '0;
    logic [2:0]  xfer_outcome = '0;
    logic [11:0] xfer_count = '0;
    logic [7:0]  pkt_pid;
    logic [6:0]  pkt_addr;
    logic [3:0]  pkt_endp;
    logic [10:0] pkt_maxlen;
    logic        out_valid;
    logic [31:0] upd_ctrl;
    logic [1:0]  upd_result;
    logic        cause_ioc, cause_short, err_ctl, err_proc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic [31:0] c;
        logic [1:0]  r;
        logic        ioc, sh, ue, pe;
    } exp_t;

    exp_t  q[$];
    string tq[$];

    always #2 clk = ~clk;

    td_status_updater #(.CNT_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .td_ctrl(td_ctrl),
        .td_token(td_token), .xfer_outcome(xfer_outcome), .xfer_count(xfer_count),
        .pkt_pid(pkt_pid), .pkt_addr(pkt_addr), .pkt_endp(pkt_endp),
        .pkt_maxlen(pkt_maxlen), .out_valid(out_valid), .upd_ctrl(upd_ctrl),
        .upd_result(upd_result), .cause_ioc(cause_ioc), .cause_short(cause_short),
        .err_ctl(err_ctl), .err_proc(err_proc)
    );

    localparam logic [31:0] ACT = 32'h0080_0000;
    localparam logic [31:0] IOC = 32'h0100_0000;
    localparam logic [31:0] ISO = 32'h0200_0000;
    localparam logic [31:0] SPD = 32'h2000_0000;

    function automatic logic [31:0] mk_tok(input logic [10:0] mf, input logic [3:0] ep,
                                           input logic [6:0] ad, input logic [7:0] pid);
        return {mf, 2'b00, ep, ad, pid};
    endfunction

    function automatic exp_t model(input logic [31:0] ctrl, input logic [31:0] tok,
                                   input logic [2:0] kind, input logic [11:0] cnt);
        exp_t e;
        logic [7:0]  pid;
        logic [10:0] ml, len;
        logic [1:0]  er;
        logic [31:0] c;
        bit tmo, bab, isin, issu;
        e = '0;
        pid = tok[7:0];
        ml = tok[31:21] + 11'd1;
        isin = (pid == 8'h69);
        issu = (pid == 8'h2D);
        if (!ctrl[23]) begin
            e.c = ctrl; e.r = 2'd1; e.ioc = ctrl[24];
            return e;
        end
        if (!(isin || issu || pid == 8'hE1)) begin
            e.c = ctrl; e.r = 2'd2; e.pe = 1'b1;
            return e;
        end
        c = ctrl & ~32'h007E_0000;
        len = ml; tmo = 0; bab = 0;
        if (kind == 3'd0) begin
            if (isin) begin
                if ({1'b0, cnt} > {2'b00, ml}) bab = 1; else len = cnt[10:0];
            end
            if (!bab) begin
                c[10:0] = len - 11'd1; c[23] = 1'b0;
                if (isin && ctrl[29] && len < ml) begin e.sh = 1; e.r = 2'd1; end
                else e.r = 2'd0;
            end
        end else if (kind == 3'd2) begin
            c[19] = 1'b1; e.r = 2'd1;
            if (issu) tmo = 1;
        end else if (kind == 3'd3) begin
            c[22] = 1'b1; c[23] = 1'b0; e.r = 2'd1;
        end else if (kind == 3'd4) begin
            bab = 1;
        end else begin
            tmo = 1;
        end
        if (bab) begin c[20] = 1; c[22] = 1; c[23] = 0; e.r = 2'd2; end
        if (tmo) begin
            c[18] = 1'b1; er = c[28:27]; e.r = 2'd1;
            if (er != 0) begin
                er = er - 2'd1;
                if (er == 0) begin c[23] = 0; e.ue = 1; end
            end
            c[28:27] = er;
        end
        if (c[25]) c[23] = 1'b0;
        e.ioc = c[24] & ~c[23];
        e.c = c;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: assumes it is entered at a negative edge
    task automatic send(input string tag, input logic [31:0] ctrl, input logic [31:0] tok,
                        input logic [2:0] kind, input logic [11:0] cnt);
        td_ctrl = ctrl; td_token = tok; xfer_outcome = kind; xfer_count = cnt;
        in_valid = 1'b1;
        q.push_back(model(ctrl, tok, kind, cnt));
        tq.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk("R3 spurious out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                chk({t, " ctrl"},   upd_ctrl, e.c);
                chk({t, " result"}, {30'd0, upd_result}, {30'd0, e.r});
                chk({t, " causes"}, {28'd0, cause_ioc, cause_short, err_ctl, err_proc},
                                    {28'd0, e.ioc, e.sh, e.ue, e.pe});
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3 reset state
        chk("R3 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R3 reset ctrl", upd_ctrl, 32'd0);
        chk("R3 reset flags", {26'd0, upd_result, cause_ioc, cause_short, err_ctl, err_proc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 decode
        td_token = mk_tok(11'd63, 4'hA, 7'h55, 8'h69);
        #1;
        chk("R2 pid",  {24'd0, pkt_pid}, 32'h69);
        chk("R2 addr", {25'd0, pkt_addr}, 32'h55);
        chk("R2 endp", {28'd0, pkt_endp}, 32'hA);
        chk("R2 maxlen", {21'd0, pkt_maxlen}, 32'd64);
        td_token = mk_tok(11'h7FF, 4'h0, 7'h00, 8'hE1);
        #1;
        chk("R2 maxlen wrap", {21'd0, pkt_maxlen}, 32'd0);
        @(negedge clk);

        // R1 inactive, with IOC and stale status
        send("R1 inactive", IOC | 32'h0024_0005, mk_tok(11'd7, 4'd1, 7'd2, 8'h69), 3'd1, 12'd0);
        idle(2);
        // R5 OUT success, count ignored; R4 stale status cleared
        send("R5 R4 out ok", ACT | 32'h0020_0000 | 32'h1800_0000, mk_tok(11'd15, 4'd2, 7'd3, 8'hE1), 3'd0, 12'd3);
        idle(1);
        // R5 SETUP success with IOC (R14)
        send("R5 R14 setup ok", ACT | IOC, mk_tok(11'd7, 4'd0, 7'd1, 8'h2D), 3'd0, 12'd0);
        idle(1);
        // R7 IN short with SPD
        send("R7 in short spd", ACT | SPD | IOC, mk_tok(11'd63, 4'd1, 7'd4, 8'h69), 3'd0, 12'd10);
        idle(1);
        // R7 IN short without SPD advances
        send("R7 in short nospd", ACT, mk_tok(11'd63, 4'd1, 7'd4, 8'h69), 3'd0, 12'd10);
        idle(1);
        // R5 IN exact count with SPD
        send("R5 in exact", ACT | SPD, mk_tok(11'd63, 4'd1, 7'd4, 8'h69), 3'd0, 12'd64);
        idle(1);
        // R6 IN over by one -> babble
        send("R6 in over", ACT | IOC | 32'h0000_0123, mk_tok(11'd63, 4'd1, 7'd4, 8'h69), 3'd0, 12'd65);
        idle(1);
        // R5 max field 0x7FF, zero length IN
        send("R5 zero length", ACT, mk_tok(11'h7FF, 4'd1, 7'd4, 8'h69), 3'd0, 12'd0);
        idle(1);
        // R8 timeout counter 3 -> 2
        send("R8 tmo 3to2", ACT | 32'h1800_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 3'd1, 12'd0);
        idle(1);
        // R8 counter 1 -> 0, controller error
        send("R8 tmo 1to0", ACT | IOC | 32'h0800_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'hE1), 3'd1, 12'd0);
        idle(1);
        // R8 counter already 0, unused outcome code 6
        send("R8 tmo zero", ACT, mk_tok(11'd7, 4'd0, 7'd1, 8'hE1), 3'd6, 12'd0);
        idle(1);
        // R9 NAK on IN
        send("R9 nak in", ACT | 32'h1000_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 3'd2, 12'd0);
        idle(1);
        // R9 NAK on SETUP becomes timeout, counter 1 -> 0
        send("R9 nak setup", ACT | 32'h0800_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'h2D), 3'd2, 12'd0);
        idle(1);
        // R10 stall
        send("R10 stall", ACT | IOC, mk_tok(11'd7, 4'd0, 7'd1, 8'hE1), 3'd3, 12'd0);
        idle(1);
        // R11 babble outcome, length field kept
        send("R11 babble", ACT | 32'h0000_0055, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 3'd4, 12'd0);
        idle(1);
        // R12 illegal PID, stale status kept
        send("R12 bad pid", ACT | IOC | 32'h0044_0000, mk_tok(11'd7, 4'd0, 7'd1, 8'hA5), 3'd0, 12'd0);
        idle(1);
        // R13 iso forces inactive under NAK, IOC raised (R14)
        send("R13 iso nak", ACT | ISO | IOC, mk_tok(11'd7, 4'd0, 7'd1, 8'h69), 3'd2, 12'd0);
        idle(1);
        // R3 back-to-back strobes
        send("R3 b2b first", ACT, mk_tok(11'd3, 4'd0, 7'd1, 8'hE1), 3'd0, 12'd0);
        send("R3 b2b second", ACT | 32'h1000_0000, mk_tok(11'd3, 4'd0, 7'd1, 8'hE1), 3'd1, 12'd0);
        send("R3 b2b third", ACT | IOC, mk_tok(11'd3, 4'd0, 7'd1, 8'h69), 3'd3, 12'd0);
        idle(3);
        chk("R3 all results seen", q.size(), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule